// File: doc/BRIEF.md
# DMA Interrupt Status Controller

This block gathers the completion and fault causes of a DMA channel into one sticky status register. Each cause arrives as a single-cycle pulse from the event or transfer logic. The pulse sets its own status bit, and that bit holds until software clears it. A separate enable register chooses which latched causes count toward the interrupt. A write-one-to-clear register lets software acknowledge causes one by one or all together.

The effective cause is the status ANDed with the enable. A control bit selects how the effective cause is delivered:
- In wired mode, a level interrupt line stays high while any effective cause remains.
- In message mode, the wired line is held low and a one-cycle request pulse marks each transition from "nothing pending" to "something pending". The logic that turns that pulse into a message sits outside this block.

A separate flag tells software whether any enabled cause is an error rather than a normal completion.

Software reaches the registers through a simple synchronous bus with registered read data.

Top module: `dmairq_status_ctrl`

## Requirements
- R1: After a synchronous reset, status, enable and control read as zero, and `irq_line`, `err_flag` and `msg_pulse` are low.
- R2: A pulse on `cause_in` bit 0, 1, 9, 10, 11 or 14 sets the status bit at the same position, visible after the next clock edge. Pulses on any other bit are ignored, and those status bits read 0.
- R3: Status bits latch whatever the enable says. Writing the enable register (offset 0x110, unimplemented bits read 0) takes effect at the edge that accepts the write, so an already-latched cause raises `irq_line` immediately.
- R4: A write to offset 0x108 clears every status bit where the write data holds a one. Zero bits have no effect. Reading 0x108 returns 0, and writes to the status register at 0x100 are ignored.
- R5: A cause pulse in the same cycle as a clear of that bit leaves the bit set.
- R6: With control bit 0 at 0 (wired mode), `irq_line` equals the OR of status AND enable. It stays high until every enabled pending bit has been cleared or disabled.
- R7: `err_flag` is high exactly when an enabled status bit among positions 1, 9, 10, 11 and 14 is set. Bit 0 (completion) never raises it.
- R8: With control bit 0 at 1 (message mode, register offset 0x004), `irq_line` stays low. `msg_pulse` is high for exactly one cycle when the effective cause goes from zero to non-zero.
- R9: Read data appears on `bus_rdata` one cycle after a read request. Offsets other than 0x004, 0x100, 0x108 and 0x110 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cause_in | input | 16 | Single-cycle cause pulses, one bit per cause position |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_line | output | 1 | Level interrupt in wired mode |
| msg_pulse | output | 1 | One-cycle delivery request in message mode |
| err_flag | output | 1 | Any enabled error cause pending |

## Verification
The assertions assume that `cause_in` and the bus strobes are free of X after reset, and that a read and a write never share a cycle. The assertions on the enable and clear registers depend on that second point. The stimulus drives every input on the falling edge, issues one bus operation at a time, and keeps each cause pulse to a single cycle. Clears are issued only on their own, except in the one test that deliberately overlaps a clear with a cause.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    localparam int CAUSE_W = 16;

    // cause positions
    localparam int CS_DONE      = 0;
    localparam int CS_EVWR_ERR  = 1;
    localparam int CS_DESC_ERR  = 9;
    localparam int CS_RD_ERR    = 10;
    localparam int CS_WR_ERR    = 11;
    localparam int CS_BAD_DESC  = 14;

    localparam logic [CAUSE_W-1:0] ERR_MASK =
        CAUSE_W'((1 << CS_EVWR_ERR) | (1 << CS_DESC_ERR) | (1 << CS_RD_ERR) |
                 (1 << CS_WR_ERR) | (1 << CS_BAD_DESC));
    localparam logic [CAUSE_W-1:0] IMPL_MASK = ERR_MASK | CAUSE_W'(1 << CS_DONE);

    // register offsets
    localparam int OFS_CTRL   = 'h004;
    localparam int OFS_STATUS = 'h100;
    localparam int OFS_CLEAR  = 'h108;
    localparam int OFS_ENABLE = 'h110;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STATUS,
        SEL_CLEAR,
        SEL_ENABLE
    } reg_sel_e;

    typedef struct packed {
        logic                 msg_mode;
        logic [CAUSE_W-1:0]   enable;
    } cfg_t;

    function automatic reg_sel_e decode_ofs(input int unsigned ofs);
        case (ofs)
            OFS_CTRL:   return SEL_CTRL;
            OFS_STATUS: return SEL_STATUS;
            OFS_CLEAR:  return SEL_CLEAR;
            OFS_ENABLE: return SEL_ENABLE;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dmairq_regif.sv
module dmairq_regif
    import dmairq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [CAUSE_W-1:0]   status_i,
    output logic [CAUSE_W-1:0]   clr_mask_o,
    output cfg_t                 cfg_o,
    output logic [DATA_W-1:0]    bus_rdata
);

    reg_sel_e             sel;
    cfg_t                 cfg_q;
    logic [DATA_W-1:0]    rdata_q;
    logic [DATA_W-1:0]    rdata_n;
    logic                 unused_wdata;

    assign sel          = decode_ofs(int'(unsigned'(bus_addr)));
    assign unused_wdata = ^bus_wdata[DATA_W-1:CAUSE_W];

    assign clr_mask_o = (bus_wr && sel == SEL_CLEAR) ? bus_wdata[CAUSE_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (bus_wr) begin
            if (sel == SEL_CTRL)
                cfg_q.msg_mode <= bus_wdata[0];
            if (sel == SEL_ENABLE)
                cfg_q.enable <= bus_wdata[CAUSE_W-1:0] & IMPL_MASK;
        end
    end

    always_comb begin
        rdata_n = '0;
        case (sel)
            SEL_CTRL:   rdata_n = DATA_W'(cfg_q.msg_mode);
            SEL_STATUS: rdata_n = DATA_W'(status_i);
            SEL_ENABLE: rdata_n = DATA_W'(cfg_q.enable);
            default:    rdata_n = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (bus_rd)
            rdata_q <= rdata_n;
    end

    assign cfg_o     = cfg_q;
    assign bus_rdata = rdata_q;

    AST_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_ENABLE) |=> (cfg_q.enable == ($past(bus_wdata[CAUSE_W-1:0]) & IMPL_MASK))) // R3
        else $error("enable write not taken");
    AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == SEL_CLEAR) |=> (bus_rdata == '0)) // R4
        else $error("clear register read non-zero");

endmodule

// File: rtl/dmairq_status.sv
module dmairq_status
    import dmairq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CAUSE_W-1:0]   cause_in,
    input  logic [CAUSE_W-1:0]   clr_mask,
    output logic [CAUSE_W-1:0]   status_o
);

    logic unused_cause;
    assign unused_cause = ^(cause_in & ~IMPL_MASK);

    for (genvar i = 0; i < CAUSE_W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_flop
            logic st_q;
            always_ff @(posedge clk) begin
                if (rst)
                    st_q <= 1'b0;
                else if (cause_in[i])
                    st_q <= 1'b1;      // cause wins over a clear in the same cycle
                else if (clr_mask[i])
                    st_q <= 1'b0;
            end
            assign status_o[i] = st_q;
        end else begin : g_tie
            assign status_o[i] = 1'b0;
        end
    end

    AST_CAUSE_SETS: assert property (@(posedge clk) disable iff (rst)
        ((cause_in & IMPL_MASK) != '0) |=>
            ((status_o & $past(cause_in & IMPL_MASK)) == $past(cause_in & IMPL_MASK))) // R2
        else $error("cause did not latch");
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        ((clr_mask & ~cause_in) != '0) |=> ((status_o & $past(clr_mask & ~cause_in)) == '0)) // R4
        else $error("clear did not take");
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cause_in == '0 && clr_mask == '0) |=> $stable(status_o)) // R3
        else $error("status changed without cause or clear");

endmodule

// File: rtl/dmairq_deliver.sv
module dmairq_deliver
    import dmairq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CAUSE_W-1:0]   status_i,
    input  logic [CAUSE_W-1:0]   clr_mask,
    input  cfg_t                 cfg_i,
    output logic                 irq_line,
    output logic                 msg_pulse,
    output logic                 err_flag
);

    logic [CAUSE_W-1:0] eff;
    logic               pend;
    logic               pend_q;

    assign eff      = status_i & cfg_i.enable;
    assign pend     = |eff;
    assign err_flag = |(eff & ERR_MASK);
    assign irq_line = pend & ~cfg_i.msg_mode;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else
            pend_q <= pend;
    end

    assign msg_pulse = cfg_i.msg_mode & pend & ~pend_q;

    AST_MSG_QUIET_LINE: assert property (@(posedge clk) disable iff (rst)
        cfg_i.msg_mode |-> !irq_line) // R8
        else $error("wired line high in message mode");
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        msg_pulse |=> !msg_pulse) // R8
        else $error("message pulse longer than one cycle");
    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (irq_line && clr_mask == '0) |=>
            (irq_line || cfg_i.msg_mode || cfg_i.enable != $past(cfg_i.enable))) // R6
        else $error("interrupt dropped without clear");
    AST_ERR_HAS_IRQ: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> (irq_line || cfg_i.msg_mode)) // R7
        else $error("error flag without interrupt");

endmodule

// File: rtl/dmairq_status_ctrl.sv
module dmairq_status_ctrl
    import dmairq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CAUSE_W-1:0]   cause_in,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq_line,
    output logic                 msg_pulse,
    output logic                 err_flag
);

    logic [CAUSE_W-1:0] status;
    logic [CAUSE_W-1:0] clr_mask;
    cfg_t               cfg;

    dmairq_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .status_i   (status),
        .clr_mask_o (clr_mask),
        .cfg_o      (cfg),
        .bus_rdata  (bus_rdata)
    );

    dmairq_status u_status (
        .clk      (clk),
        .rst      (rst),
        .cause_in (cause_in),
        .clr_mask (clr_mask),
        .status_o (status)
    );

    dmairq_deliver u_deliver (
        .clk       (clk),
        .rst       (rst),
        .status_i  (status),
        .clr_mask  (clr_mask),
        .cfg_i     (cfg),
        .irq_line  (irq_line),
        .msg_pulse (msg_pulse),
        .err_flag  (err_flag)
    );

    AST_RST_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!irq_line && !msg_pulse && !err_flag)) // R1
        else $error("outputs active after reset");

endmodule

// File: tb/dmairq_status_ctrl_tb.sv
`timescale 1ns/1ps
module dmairq_status_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cause_in = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_line, msg_pulse, err_flag;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd;

    localparam logic [11:0] A_CTRL = 12'h004;
    localparam logic [11:0] A_ST   = 12'h100;
    localparam logic [11:0] A_CLR  = 12'h108;
    localparam logic [11:0] A_EN   = 12'h110;

    always #2 clk = ~clk;

    dmairq_status_ctrl u_dut (
        .clk(clk), .rst(rst), .cause_in(cause_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_line(irq_line), .msg_pulse(msg_pulse), .err_flag(err_flag)
    );

    typedef struct packed {
        logic [15:0] cause;
        logic [15:0] clr;
        logic [15:0] en;
        logic [15:0] st;
        logic        irq;
        logic        err;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{16'h0001, 16'h0000, 16'hFFFF, 16'h0001, 1'b1, 1'b0},
        '{16'h0002, 16'h0000, 16'h0002, 16'h0002, 1'b1, 1'b1},
        '{16'h4E03, 16'h0E00, 16'hFFFF, 16'h4003, 1'b1, 1'b1},
        '{16'h8000, 16'h0000, 16'hFFFF, 16'h0000, 1'b0, 1'b0},
        '{16'h0400, 16'h0400, 16'hFFFF, 16'h0000, 1'b0, 1'b0},
        '{16'h0200, 16'h0000, 16'h0001, 16'h0200, 1'b0, 1'b0},
        '{16'h0801, 16'h0800, 16'h0001, 16'h0001, 1'b1, 1'b0},
        '{16'h4000, 16'h0000, 16'h0000, 16'h4000, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [15:0] c);
        @(negedge clk);
        cause_in = c;
        @(negedge clk);
        cause_in = '0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {31'b0, irq_line}, 0);
        chk("R1 err", {31'b0, err_flag}, 0);
        chk("R1 msg", {31'b0, msg_pulse}, 0);
        rdreg(A_ST, rd);   chk("R1 status", rd, 0);
        rdreg(A_EN, rd);   chk("R1 enable", rd, 0);
        rdreg(A_CTRL, rd); chk("R1 ctrl", rd, 0);

        // table: R2 R4 R6 R7
        for (int i = 0; i < 8; i++) begin
            wr(A_CLR, 32'hFFFF);
            wr(A_EN, {16'h0, VEC[i].en});
            pulse(VEC[i].cause);
            wr(A_CLR, {16'h0, VEC[i].clr});
            chk("R6 irq_line vec", {31'b0, irq_line}, {31'b0, VEC[i].irq});
            chk("R7 err_flag vec", {31'b0, err_flag}, {31'b0, VEC[i].err});
            rdreg(A_ST, rd);
            chk("R2 status vec", rd, {16'h0, VEC[i].st});
            rdreg(A_EN, rd);
            chk("R3 enable readback", rd, {16'h0, VEC[i].en & 16'h4E03});
        end

        // R3 latched while disabled, exposed on enable
        wr(A_CLR, 32'hFFFF);
        wr(A_EN, 32'h0);
        pulse(16'h0800);
        chk("R3 irq low while disabled", {31'b0, irq_line}, 0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_EN; bus_wdata = 32'h0800;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R3 irq after enable", {31'b0, irq_line}, 1);
        chk("R7 err after enable", {31'b0, err_flag}, 1);

        // R4 zero clear no effect, status write ignored, clear reads 0
        wr(A_CLR, 32'h0);
        chk("R4 zero clear", {31'b0, irq_line}, 1);
        wr(A_ST, 32'h0);
        rdreg(A_ST, rd); chk("R4 status write ignored", rd, 32'h0800);
        rdreg(A_CLR, rd); chk("R4 clear reads zero", rd, 0);

        // R5 cause and clear same cycle
        wr(A_EN, 32'hFFFF);
        @(negedge clk);
        cause_in = 16'h0001; bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h0801;
        @(negedge clk);
        cause_in = '0; bus_wr = 1'b0;
        rdreg(A_ST, rd); chk("R5 cause beats clear", rd, 32'h0001);

        // R6 stays high until every enabled bit cleared
        pulse(16'h4000);
        wr(A_CLR, 32'h0001);
        chk("R6 still pending", {31'b0, irq_line}, 1);
        chk("R7 bit14 error", {31'b0, err_flag}, 1);
        wr(A_CLR, 32'h4000);
        chk("R6 all cleared", {31'b0, irq_line}, 0);

        // R7 completion alone never raises error
        pulse(16'h0001);
        chk("R7 completion no err", {31'b0, err_flag}, 0);
        chk("R6 completion irq", {31'b0, irq_line}, 1);
        wr(A_CLR, 32'hFFFF);

        // R8 message mode
        wr(A_CTRL, 32'h1);
        rdreg(A_CTRL, rd); chk("R8 ctrl readback", rd, 1);
        pulse(16'h0200);
        chk("R8 pulse high", {31'b0, msg_pulse}, 1);
        chk("R8 wired low", {31'b0, irq_line}, 0);
        @(negedge clk);
        chk("R8 pulse one cycle", {31'b0, msg_pulse}, 0);
        pulse(16'h0001);
        chk("R8 no pulse while pending", {31'b0, msg_pulse}, 0);
        wr(A_CLR, 32'hFFFF);
        pulse(16'h0400);
        chk("R8 pulse again after drain", {31'b0, msg_pulse}, 1);
        wr(A_CTRL, 32'h0);
        chk("R6 wired after mode change", {31'b0, irq_line}, 1);

        // R9 unmapped offsets and latency
        rdreg(12'h008, rd); chk("R9 unmapped read", rd, 0);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = A_ST;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R9 one-cycle latency", bus_rdata, 32'h0400);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule